// File: doc/BRIEF.md
# Camera Sync Mode Control Register

This block holds the operating mode of a four-channel camera synchronization controller. Software sets it up through a simple register bus. Each write is one data word sent to the block's own address. The stored mode drives five things: a module enable, a timestamp-send enable, a choice between the received and the local timestamp, a choice between triggered and free-running sensor operation, and a master channel number and a per-channel enable mask.

Every field except the module enable has its own update bit inside the written word. Software can therefore change one field and leave the others as they are, with no need to read the register first. The module enable is not protected this way. Every write to the register sets it again, and a 0 there holds the downstream synchronization logic in reset.

Top module: `sync_mode_reg`

## Requirements
- R1: While `rst` is high, and on the first edge after it, every stored field is 0. The channel mask is 0000, so all channels are disabled.
- R2: Every accepted write loads data bit 0 into `mod_en`. This bit has no update bit of its own.
- R3: The timestamp-send flag uses data bits 2:1 as a 2-bit code. Code 2 clears the flag, code 3 sets it, and codes 0 and 1 keep its value.
- R4: The external-timestamp flag uses bits 4:3 and the triggered-mode flag uses bits 6:5. Both follow the same code as R3, and each flag is independent of the others.
- R5: The master channel uses bits 9:7. When bit 9 is 1, the channel is loaded from bits 8:7. When bit 9 is 0, the channel is kept.
- R6: The channel mask uses bits 14:10. When bit 14 is 1, the mask is loaded from bits 13:10. When bit 14 is 0, the mask is kept.
- R7: A write is accepted only when `wr_en` is 1 and `wr_addr` equals `SELF_ADDR`. Any other cycle leaves every field unchanged.
- R8: `mode_word` shows the stored state. Bit 0 is the module enable. Bits 1, 2 and 3 are the send, external and triggered flags. Bits 5:4 are the master channel and bits 9:6 are the mask. Each field change shows on the edge that accepts the write.
- R9: Data bits above 14 have no effect on any field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data word |
| mod_en | output | 1 | Module enable (0 holds sync logic in reset) |
| snd_ts_en | output | 1 | Send timestamp with sync pulse |
| ext_ts_sel | output | 1 | 1: use received timestamp, 0: local |
| trig_mode | output | 1 | 1: triggered sensor mode, 0: free running |
| master_chn | output | 2 | Master channel number |
| chn_mask | output | 4 | Per-channel enable mask |
| mode_word | output | 10 | Packed register contents (layout in R8) |

## Verification
The bench sweeps all 32768 values of the low 15 data bits as accepted writes, taken in order. Because the order is fixed, every keep code meets stored values of both polarities, so a field that reloads when it should keep is told apart from one that holds. Different junk in the upper data bits goes with each write, which separates decoders that look at bits above 14. After each accepted write come a write to a neighbouring address and a write to the block's own address with the strobe low. Both carry the inverted pattern, and they show whether the address match and the strobe qualification are each needed on their own.

// File: rtl/sync_mode_pkg.sv
package sync_mode_pkg;

    localparam int NUM_CHN = 4;
    localparam int CHN_W   = $clog2(NUM_CHN);
    localparam int FLAG_N  = 3;            // send, external ts, triggered

    // write-word field positions
    localparam int EN_POS   = 0;
    localparam int FLAG_LSB = 1;           // flag i occupies [FLAG_LSB+2i +: 2]
    localparam int MST_LSB  = FLAG_LSB + 2 * FLAG_N;
    localparam int MSK_LSB  = MST_LSB + CHN_W + 1;
    localparam int WORD_W   = MSK_LSB + NUM_CHN + 1;

    typedef struct packed {
        logic [NUM_CHN-1:0] mask;
        logic [CHN_W-1:0]   master;
        logic [FLAG_N-1:0]  flags;
        logic               en;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef struct packed {
        logic               en_val;
        logic [FLAG_N-1:0]  flag_upd;
        logic [FLAG_N-1:0]  flag_val;
        logic               mst_upd;
        logic [CHN_W-1:0]   mst_val;
        logic               msk_upd;
        logic [NUM_CHN-1:0] msk_val;
    } upd_t;

    // 2-bit flag code: upper bit requests update, lower bit is the value
    function automatic logic code_upd(input logic [1:0] code);
        return code[1];
    endfunction

    function automatic logic code_val(input logic [1:0] code);
        return code[0];
    endfunction

endpackage

// File: rtl/sync_mode_decode.sv
module sync_mode_decode
    import sync_mode_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter int              DATA_W    = 32,
    parameter logic [ADDR_W-1:0] SELF_ADDR = 8'h04
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              hit,
    output upd_t              upd
);

    logic [WORD_W-1:0] word;
    assign word = wr_data[WORD_W-1:0];
    assign hit  = wr_en && (wr_addr == SELF_ADDR);

    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        logic [1:0] code;
        assign code             = word[FLAG_LSB + 2*i +: 2];
        assign upd.flag_upd[i]  = code_upd(code);
        assign upd.flag_val[i]  = code_val(code);
    end

    assign upd.en_val  = word[EN_POS];
    assign upd.mst_upd = word[MST_LSB + CHN_W];
    assign upd.mst_val = word[MST_LSB +: CHN_W];
    assign upd.msk_upd = word[MSK_LSB + NUM_CHN];
    assign upd.msk_val = word[MSK_LSB +: NUM_CHN];

endmodule

// File: rtl/sync_mode_field.sv
module sync_mode_field #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= val;
    end

endmodule

// File: rtl/sync_mode_reg.sv
module sync_mode_reg
    import sync_mode_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] SELF_ADDR = 8'h04
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              mod_en,
    output logic              snd_ts_en,
    output logic              ext_ts_sel,
    output logic              trig_mode,
    output logic [1:0]        master_chn,
    output logic [3:0]        chn_mask,
    output logic [9:0]        mode_word
);

    logic  hit;
    upd_t  upd;
    mode_t cur;

    sync_mode_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SELF_ADDR(SELF_ADDR)
    ) u_dec (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .hit    (hit),
        .upd    (upd)
    );

    // module enable: rewritten on every accepted write
    sync_mode_field #(.W(1)) u_en (
        .clk (clk), .rst(rst), .load(hit),
        .val (upd.en_val), .q(cur.en)
    );

    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        sync_mode_field #(.W(1)) u_f (
            .clk (clk), .rst(rst), .load(hit && upd.flag_upd[i]),
            .val (upd.flag_val[i]), .q(cur.flags[i])
        );
    end

    sync_mode_field #(.W(CHN_W)) u_mst (
        .clk (clk), .rst(rst), .load(hit && upd.mst_upd),
        .val (upd.mst_val), .q(cur.master)
    );

    sync_mode_field #(.W(NUM_CHN)) u_msk (
        .clk (clk), .rst(rst), .load(hit && upd.msk_upd),
        .val (upd.msk_val), .q(cur.mask)
    );

    assign mod_en     = cur.en;
    assign snd_ts_en  = cur.flags[0];
    assign ext_ts_sel = cur.flags[1];
    assign trig_mode  = cur.flags[2];
    assign master_chn = cur.master;
    assign chn_mask   = cur.mask;
    assign mode_word  = cur;

endmodule

// File: rtl/sync_mode_reg_chk.sv
module sync_mode_reg_chk #(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] SELF_ADDR = 8'h04
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              mod_en,
    input logic [1:0]        master_chn,
    input logic [3:0]        chn_mask,
    input logic [9:0]        mode_word
);

    logic acc;
    assign acc = wr_en && (wr_addr == SELF_ADDR);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (mode_word == '0));

    a_r2_enable_load: assert property (@(posedge clk) disable iff (rst)
        acc |=> (mod_en == $past(wr_data[0])));

    a_r3_send_keep: assert property (@(posedge clk) disable iff (rst)
        (acc && !wr_data[2]) |=> $stable(mode_word[1]));

    a_r4_trig_keep: assert property (@(posedge clk) disable iff (rst)
        (acc && !wr_data[6]) |=> $stable(mode_word[3]));

    a_r5_master_load: assert property (@(posedge clk) disable iff (rst)
        (acc && wr_data[9]) |=> (master_chn == $past(wr_data[8:7])));

    a_r6_mask_load: assert property (@(posedge clk) disable iff (rst)
        (acc && wr_data[14]) |=> (chn_mask == $past(wr_data[13:10])));

    a_r7_no_access_hold: assert property (@(posedge clk) disable iff (rst)
        !acc |=> $stable(mode_word));

endmodule

bind sync_mode_reg sync_mode_reg_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SELF_ADDR(SELF_ADDR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .mod_en    (mod_en),
    .master_chn(master_chn),
    .chn_mask  (chn_mask),
    .mode_word (mode_word)
);

// File: tb/sync_mode_reg_tb.sv
module sync_mode_reg_tb;

    localparam int          ADDR_W = 8;
    localparam int          DATA_W = 32;
    localparam logic [7:0]  ME     = 8'h04;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              mod_en, snd_ts_en, ext_ts_sel, trig_mode;
    logic [1:0]        master_chn;
    logic [3:0]        chn_mask;
    logic [9:0]        mode_word;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    // expected model
    logic       e_en, e_snd, e_ext, e_trg;
    logic [1:0] e_mst;
    logic [3:0] e_msk;

    always #5 clk = ~clk;

    sync_mode_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SELF_ADDR(ME)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mod_en(mod_en), .snd_ts_en(snd_ts_en), .ext_ts_sel(ext_ts_sel),
        .trig_mode(trig_mode), .master_chn(master_chn), .chn_mask(chn_mask),
        .mode_word(mode_word)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string ctx);
        chk({"R2 mod_en ", ctx}, mod_en, e_en);
        chk({"R3 snd ", ctx}, snd_ts_en, e_snd);
        chk({"R4 ext ", ctx}, ext_ts_sel, e_ext);
        chk({"R4 trig ", ctx}, trig_mode, e_trg);
        chk({"R5 master ", ctx}, master_chn, e_mst);
        chk({"R6 mask ", ctx}, chn_mask, e_msk);
        chk({"R8 word ", ctx}, mode_word,
            int'(e_en) + 2*int'(e_snd) + 4*int'(e_ext) + 8*int'(e_trg)
            + 16*int'(e_mst) + 64*int'(e_msk));
    endtask

    function automatic logic flag_next(input logic cur, input int code);
        if (code == 2) return 1'b0;
        if (code == 3) return 1'b1;
        return cur;
    endfunction

    task automatic cycle_once();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
            finish_run();
        end
    end

    initial begin
        e_en = 0; e_snd = 0; e_ext = 0; e_trg = 0; e_mst = 0; e_msk = 0;
        @(negedge clk);
        // preload nonzero state through a write while reset is high: R1
        wr_en = 1; wr_addr = ME; wr_data = 32'h7FFF;
        cycle_once();
        cycle_once();
        check_all("R1 reset");
        rst = 0;
        wr_en = 0;
        cycle_once();
        check_all("R1 after reset");

        for (int v = 0; v < 32768; v++) begin
            // accepted write with junk in upper bits (R9)
            wr_en   = 1;
            wr_addr = ME;
            wr_data = {17'(v * 37 + 5), 15'(v)};
            cycle_once();
            e_en  = v[0];
            e_snd = flag_next(e_snd, (v >> 1) & 3);
            e_ext = flag_next(e_ext, (v >> 3) & 3);
            e_trg = flag_next(e_trg, (v >> 5) & 3);
            if (v[9])  e_mst = 2'(v >> 7);
            if (v[14]) e_msk = 4'(v >> 10);
            check_all("R9 write");

            // wrong address: R7
            wr_addr = ME ^ 8'h01;
            wr_data = {17'h1FFFF, ~15'(v)};
            cycle_once();
            chk("R7 wrong address", mode_word,
                int'(e_en) + 2*int'(e_snd) + 4*int'(e_ext) + 8*int'(e_trg)
                + 16*int'(e_mst) + 64*int'(e_msk));

            // strobe low at own address: R7
            wr_addr = ME;
            wr_en   = 0;
            cycle_once();
            chk("R7 strobe low", mode_word,
                int'(e_en) + 2*int'(e_snd) + 4*int'(e_ext) + 8*int'(e_trg)
                + 16*int'(e_mst) + 64*int'(e_msk));
        end

        finish_run();
    end

endmodule